// File: doc/BRIEF.md
# ADC Auto-Trigger Source Controller

This block decides when an analog-to-digital converter begins a conversion. Seven event flags come from neighbouring logic: the analog comparator, external interrupt 0, and five timer events. A 3-bit select picks one of them, or picks free-running operation. A rising edge on the selected flag produces a start pulse one clock cycle wide, provided the converter and auto-triggering are both enabled and no conversion is in progress. The edge detector follows the multiplexer. As a result, moving the select from a source whose flag is low to one whose flag is high also counts as a trigger. Selecting free-running mode never counts as a trigger.

The converter is represented by a fixed-latency stub. It holds busy for a parameterised number of cycles and then raises a one-cycle completion flag. In free-running mode, each completion starts the next conversion on the following cycle. Free-running restarts are withheld while a differential channel is in use. Clearing the converter enable aborts a conversion that is running.

The block also holds a 16-bit digital-input disable mask, written one byte at a time. Each set mask bit forces the matching pin readback bit to zero.

Top module: `adc_trig_top`

## Requirements
- R1: `srcSelect` codes map to sources as follows: 0 is free running, 1 is `eventIn[0]` (analog comparator), 2 is `eventIn[1]` (external interrupt 0), 3 is `eventIn[2]` (timer0 compare A), 4 is `eventIn[3]` (timer0 overflow), 5 is `eventIn[4]` (timer1 compare B), 6 is `eventIn[5]` (timer1 overflow), 7 is `eventIn[6]` (timer1 capture). Only the selected flag can cause a start.
- R2: For codes 1 to 7, when the selected flag is high in a cycle and was low in the previous cycle, `startPulse` is high in the next cycle. This requires `adcEnable`, `autoTrigEnable` and not busy; with either enable low no start is issued.
- R3: Changing `srcSelect` from a source whose flag is low to a source whose flag is high produces a start in the next cycle.
- R4: Changing `srcSelect` to 0 never produces a start, even when `doneFlag` (the sticky completion interrupt flag) is high. Edges on `doneFlag` never produce a start.
- R5: With code 0, enables high and `diffChannel` low, `startPulse` is high in the cycle right after each `convDone` cycle.
- R6: With code 0 and `diffChannel` high, no free-running start is issued.
- R7: `startPulse` is never high for two cycles in a row. A trigger edge that arrives while `busy` is high is ignored.
- R8: `busy` rises together with `startPulse` and stays high for exactly `CONV_CYCLES` cycles. `convDone` is high for the single cycle after the last busy cycle.
- R9: When `adcEnable` is low, `busy` and `convDone` are low after the next clock. An aborted conversion never raises `convDone`.
- R10: The mask resets to zero. A high `maskWr[0]` loads `maskData` into mask bits 7:0, and a high `maskWr[1]` loads it into bits 15:8. `pinRead` equals `pinRaw` AND NOT mask.
- R11: Reset clears `startPulse`, `busy`, `convDone` and the stored previous trigger value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| adcEnable | input | 1 | Converter enable; low aborts |
| autoTrigEnable | input | 1 | Auto-trigger enable |
| diffChannel | input | 1 | A differential channel is selected |
| srcSelect | input | 3 | Trigger source code |
| eventIn | input | 7 | Event flags for source codes 1 to 7 |
| doneFlag | input | 1 | Sticky conversion-complete interrupt flag |
| maskWr | input | 2 | Byte write strobes for the mask |
| maskData | input | 8 | Mask byte to write |
| pinRaw | input | 16 | Raw digital pin levels |
| startPulse | output | 1 | One-cycle conversion start |
| busy | output | 1 | Conversion in progress |
| convDone | output | 1 | One-cycle conversion-complete flag |
| pinRead | output | 16 | Masked pin readback |

## Verification
The hardest situation to reach is the boundary between conversions. A completion cycle must hand over to a free-running restart on the very next cycle, and that restart must be withheld as soon as a differential channel is flagged. Reaching it takes a conversion launched from a timer edge, with the select switched to free running while that conversion is still running. Each completion can then be observed chaining into the next. The sticky completion flag is then held high across a switch to free running, to show that no spurious trigger appears.

// File: rtl/adc_trig_pkg.sv
package adc_trig_pkg;
  localparam int SEL_W = 3;
  localparam logic [SEL_W-1:0] SRC_FREE = '0;

  typedef struct packed {
    logic launch;
    logic abort;
  } ctlStrobes_t;
endpackage

// File: rtl/adc_trig_datapath.sv
module adc_trig_datapath
  import adc_trig_pkg::*;
#(
  parameter int NUM_SRC     = 8,
  parameter int CONV_CYCLES = 13,
  parameter int PIN_W       = 16,
  parameter int BYTE_W      = 8,
  localparam int NUM_BYTES  = PIN_W / BYTE_W,
  localparam int CNT_W      = $clog2(CONV_CYCLES + 1)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [SEL_W-1:0]     srcSelect,
  input  logic [NUM_SRC-2:0]   eventIn,
  input  logic                 doneFlag,
  input  ctlStrobes_t          strobes,
  input  logic [NUM_BYTES-1:0] maskWr,
  input  logic [BYTE_W-1:0]    maskData,
  input  logic [PIN_W-1:0]     pinRaw,
  output logic                 trigEdge,
  output logic                 startPulse,
  output logic                 busy,
  output logic                 convDone,
  output logic [PIN_W-1:0]     pinRead,
  output logic [PIN_W-1:0]     maskBits
);
  logic [NUM_SRC-1:0] trigVec;
  logic               curTrig;
  logic               prevTrig;
  logic [CNT_W-1:0]   convCnt;

  // Source multiplexer followed by the edge detector.
  assign trigVec  = {eventIn, doneFlag};
  assign curTrig  = trigVec[srcSelect];
  assign trigEdge = curTrig & ~prevTrig;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevTrig <= 1'b0;
    else       prevTrig <= curTrig;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) startPulse <= 1'b0;
    else       startPulse <= strobes.launch;
  end

  // Fixed-latency conversion stub.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy     <= 1'b0;
      convDone <= 1'b0;
      convCnt  <= '0;
    end else if (strobes.abort) begin
      busy     <= 1'b0;
      convDone <= 1'b0;
      convCnt  <= '0;
    end else if (strobes.launch) begin
      busy     <= 1'b1;
      convDone <= 1'b0;
      convCnt  <= CNT_W'(CONV_CYCLES - 1);
    end else if (busy) begin
      if (convCnt == '0) begin
        busy     <= 1'b0;
        convDone <= 1'b1;
      end else begin
        convCnt  <= convCnt - 1'b1;
        convDone <= 1'b0;
      end
    end else begin
      convDone <= 1'b0;
    end
  end

  // Digital input disable mask, one register per byte lane.
  for (genvar g = 0; g < NUM_BYTES; g++) begin : gLane
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)          maskBits[g*BYTE_W +: BYTE_W] <= '0;
      else if (maskWr[g]) maskBits[g*BYTE_W +: BYTE_W] <= maskData;
    end
  end

  assign pinRead = pinRaw & ~maskBits;
endmodule

// File: rtl/adc_trig_control.sv
module adc_trig_control
  import adc_trig_pkg::*;
(
  input  logic [SEL_W-1:0] srcSelect,
  input  logic             trigEdge,
  input  logic             convDone,
  input  logic             busy,
  input  logic             adcEnable,
  input  logic             autoTrigEnable,
  input  logic             diffChannel,
  output ctlStrobes_t      strobes
);
  logic freeRun;
  logic wantStart;

  always_comb begin
    freeRun   = (srcSelect == SRC_FREE);
    // Free running restarts only from completion, never from an edge,
    // so moving the select to code 0 cannot trigger.
    wantStart = freeRun ? (convDone & ~diffChannel) : trigEdge;
    strobes.abort  = ~adcEnable;
    strobes.launch = adcEnable & autoTrigEnable & ~busy & wantStart;
  end
endmodule

// File: rtl/adc_trig_top.sv
module adc_trig_top
  import adc_trig_pkg::*;
#(
  parameter int CONV_CYCLES = 13,
  parameter int PIN_W       = 16,
  parameter int BYTE_W      = 8,
  localparam int NUM_SRC    = 1 << SEL_W,
  localparam int NUM_BYTES  = PIN_W / BYTE_W
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 adcEnable,
  input  logic                 autoTrigEnable,
  input  logic                 diffChannel,
  input  logic [SEL_W-1:0]     srcSelect,
  input  logic [NUM_SRC-2:0]   eventIn,
  input  logic                 doneFlag,
  input  logic [NUM_BYTES-1:0] maskWr,
  input  logic [BYTE_W-1:0]    maskData,
  input  logic [PIN_W-1:0]     pinRaw,
  output logic                 startPulse,
  output logic                 busy,
  output logic                 convDone,
  output logic [PIN_W-1:0]     pinRead
);
  ctlStrobes_t      strobes;
  logic             trigEdge;
  logic [PIN_W-1:0] maskBits;

  adc_trig_control u_control (
    .srcSelect     (srcSelect),
    .trigEdge      (trigEdge),
    .convDone      (convDone),
    .busy          (busy),
    .adcEnable     (adcEnable),
    .autoTrigEnable(autoTrigEnable),
    .diffChannel   (diffChannel),
    .strobes       (strobes)
  );

  adc_trig_datapath #(
    .NUM_SRC    (NUM_SRC),
    .CONV_CYCLES(CONV_CYCLES),
    .PIN_W      (PIN_W),
    .BYTE_W     (BYTE_W)
  ) u_datapath (
    .clk       (clk),
    .rstN      (rstN),
    .srcSelect (srcSelect),
    .eventIn   (eventIn),
    .doneFlag  (doneFlag),
    .strobes   (strobes),
    .maskWr    (maskWr),
    .maskData  (maskData),
    .pinRaw    (pinRaw),
    .trigEdge  (trigEdge),
    .startPulse(startPulse),
    .busy      (busy),
    .convDone  (convDone),
    .pinRead   (pinRead),
    .maskBits  (maskBits)
  );
endmodule

// File: rtl/adc_trig_checker.sv
module adc_trig_checker #(
  parameter int PIN_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             adcEnable,
  input logic             diffChannel,
  input logic [2:0]       srcSelect,
  input logic             startPulse,
  input logic             busy,
  input logic             convDone,
  input logic [PIN_W-1:0] pinRaw,
  input logic [PIN_W-1:0] pinRead,
  input logic [PIN_W-1:0] maskBits
);
  assert_start_one_cycle_R7: assert property (@(posedge clk) disable iff (!rstN)
    startPulse |=> !startPulse);

  assert_no_start_when_busy_R7: assert property (@(posedge clk) disable iff (!rstN)
    startPulse |-> !$past(busy));

  assert_start_needs_enable_R2: assert property (@(posedge clk) disable iff (!rstN)
    startPulse |-> $past(adcEnable));

  assert_abort_clears_R9: assert property (@(posedge clk) disable iff (!rstN)
    !adcEnable |=> (!busy && !convDone));

  assert_no_diff_freerun_R6: assert property (@(posedge clk) disable iff (!rstN)
    (startPulse && $past(srcSelect) == 3'd0) |-> !$past(diffChannel));

  assert_done_follows_busy_R8: assert property (@(posedge clk) disable iff (!rstN)
    convDone |-> (!busy && $past(busy)));

  assert_mask_forces_zero_R10: assert property (@(posedge clk) disable iff (!rstN)
    ((pinRead & maskBits) == '0) && ((pinRead & ~pinRaw) == '0));
endmodule

bind adc_trig_top adc_trig_checker #(.PIN_W(PIN_W)) u_checker (.*);

// File: tb/test_adc_trig_top.sv
`timescale 1ns/1ps
module test_adc_trig_top;
  localparam int LAT = 6;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        adcEnable = 1'b0, autoTrigEnable = 1'b0, diffChannel = 1'b0;
  logic [2:0]  srcSelect = 3'd0;
  logic [6:0]  eventIn = '0;
  logic        doneFlag = 1'b0;
  logic [1:0]  maskWr = '0;
  logic [7:0]  maskData = '0;
  logic [15:0] pinRaw = 16'hFFFF;
  logic        startPulse, busy, convDone;
  logic [15:0] pinRead;

  int vecs = 0;
  int errs = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  adc_trig_top #(.CONV_CYCLES(LAT)) i_adc_trig_top (
    .clk(clk), .rstN(rstN), .adcEnable(adcEnable), .autoTrigEnable(autoTrigEnable),
    .diffChannel(diffChannel), .srcSelect(srcSelect), .eventIn(eventIn),
    .doneFlag(doneFlag), .maskWr(maskWr), .maskData(maskData), .pinRaw(pinRaw),
    .startPulse(startPulse), .busy(busy), .convDone(convDone), .pinRead(pinRead)
  );

  // Behavioural reference model, advanced on each rising clock.
  bit mPrev = 0, mBusy = 0, mDone = 0, mStart = 0;
  int mLeft = 0;
  logic [15:0] mMask = '0;

  always @(posedge clk) begin
    bit cur, fire;
    if (!rstN) begin
      mPrev = 0; mBusy = 0; mDone = 0; mStart = 0; mLeft = 0; mMask = '0;
    end else begin
      cur  = (srcSelect == 0) ? doneFlag : eventIn[srcSelect - 1];
      fire = adcEnable && autoTrigEnable && !mBusy &&
             ((srcSelect != 0 && cur && !mPrev) ||
              (srcSelect == 0 && !diffChannel && mDone));
      mStart = fire;
      if (!adcEnable) begin
        mBusy = 0; mDone = 0; mLeft = 0;
      end else if (fire) begin
        mBusy = 1; mDone = 0; mLeft = LAT;
      end else if (mBusy) begin
        mLeft--;
        if (mLeft == 0) begin mBusy = 0; mDone = 1; end
        else mDone = 0;
      end else mDone = 0;
      mPrev = cur;
      if (maskWr[0]) mMask[7:0]  = maskData;
      if (maskWr[1]) mMask[15:8] = maskData;
    end
  end

  task automatic chk(input logic [15:0] got, input logic [15:0] exp, input string tag);
    vecs++;
    if (got !== exp) begin
      errs++;
      $display("FAIL %s: got %h expected %h at %0t", tag, got, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rstN && !finished) begin
      chk(16'(startPulse), 16'(mStart), "R2 model startPulse");
      chk(16'(busy), 16'(mBusy), "R8 model busy");
      chk(16'(convDone), 16'(mDone), "R8 model convDone");
      chk(pinRead, pinRaw & ~mMask, "R10 model pinRead");
    end
  end

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    end
  endtask

  task automatic drv(); @(negedge clk); #1; endtask

  task automatic waitIdle();
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (!busy && !convDone && !startPulse) break;
    end
    #1;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    errs++;
    $display("FAIL watchdog: got hang expected completion");
    summary();
    $finish;
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    chk(16'(startPulse), 0, "R11 reset startPulse");
    chk(16'(busy), 0, "R11 reset busy");
    chk(16'(convDone), 0, "R11 reset convDone");
    chk(pinRead, 16'hFFFF, "R10 reset mask zero");
    #1 rstN = 1;

    // R2: gating by auto-trigger enable
    adcEnable = 1; srcSelect = 3'd1;
    drv(); eventIn[0] = 1;
    @(negedge clk); chk(16'(startPulse), 0, "R2 no start when auto disabled");
    #1 eventIn[0] = 0; autoTrigEnable = 1;
    drv(); eventIn[0] = 1;
    @(negedge clk); chk(16'(startPulse), 1, "R2 edge starts");
    chk(16'(busy), 1, "R8 busy with start");
    @(negedge clk); chk(16'(startPulse), 0, "R7 single cycle");
    #1 eventIn[0] = 0;
    drv(); eventIn[0] = 1;
    @(negedge clk); chk(16'(startPulse), 0, "R7 edge ignored while busy");
    waitIdle();

    // R3 and R8: selection change as a trigger, then latency count
    eventIn[0] = 0;
    drv(); eventIn[1] = 1;
    drv(); srcSelect = 3'd2;
    @(negedge clk); chk(16'(startPulse), 1, "R3 select change triggers");
    n = 0;
    while (busy && n < 50) begin n++; @(negedge clk); end
    chk(16'(n), 16'(LAT), "R8 busy length");
    chk(16'(convDone), 1, "R8 done after busy");
    @(negedge clk); chk(16'(convDone), 0, "R8 done one cycle");
    waitIdle();

    // R4: switch to free running with completion flag set
    srcSelect = 3'd1; eventIn = '0; doneFlag = 1;
    drv(); srcSelect = 3'd0;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); chk(16'(startPulse), 0, "R4 no trigger on switch to free run");
    end
    #1 doneFlag = 0;
    drv(); doneFlag = 1;
    @(negedge clk); chk(16'(startPulse), 0, "R4 flag edge ignored");
    #1;

    // R5: free-running chain after a timer-launched conversion
    srcSelect = 3'd3;
    drv(); eventIn[2] = 1;
    @(negedge clk); chk(16'(startPulse), 1, "R5 seed start");
    #1 srcSelect = 3'd0;
    for (int k = 0; k < 3; k++) begin
      n = 0;
      while (!convDone && n < 50) begin n++; @(negedge clk); end
      @(negedge clk); chk(16'(startPulse), 1, "R5 restart after done");
    end
    #1 diffChannel = 1;
    n = 0;
    while (!convDone && n < 50) begin n++; @(negedge clk); end
    for (int i = 0; i < 4; i++) begin
      @(negedge clk); chk(16'(startPulse), 0, "R6 no free run with differential");
    end
    #1 diffChannel = 0; eventIn = '0;

    // R9: abort
    srcSelect = 3'd4;
    drv(); eventIn[3] = 1;
    @(negedge clk); chk(16'(busy), 1, "R9 running before abort");
    #1 adcEnable = 0;
    @(negedge clk); chk(16'(busy), 0, "R9 busy cleared");
    for (int i = 0; i < LAT + 2; i++) begin
      @(negedge clk); chk(16'(convDone), 0, "R9 no done after abort");
    end
    #1 adcEnable = 1; eventIn = '0;
    waitIdle();

    // R1: every source code, only the selected flag counts
    for (int k = 1; k < 8; k++) begin
      srcSelect = 3'(k); eventIn = '0;
      drv(); eventIn = ~(7'd1 << (k - 1));
      @(negedge clk); chk(16'(startPulse), 0, "R1 other flags ignored");
      #1 eventIn = 7'h7F;
      @(negedge clk); chk(16'(startPulse), 1, "R1 selected flag triggers");
      waitIdle();
      eventIn = '0;
      drv();
    end

    // R10: mask bytes
    maskWr = 2'b01; maskData = 8'hA5;
    drv(); maskWr = 2'b10; maskData = 8'h3C;
    drv(); maskWr = 2'b00; pinRaw = 16'hFFFF;
    @(negedge clk); chk(pinRead, ~16'h3CA5, "R10 mask all ones");
    #1 pinRaw = 16'h5A5A;
    @(negedge clk); chk(pinRead, 16'h5A5A & ~16'h3CA5, "R10 mask pattern");
    #1;

    repeat (2) @(negedge clk);
    summary();
    $finish;
  end
endmodule